// File: doc/BRIEF.md
# Synchronous Bus Memory Cycle Master

This block turns single requests from a local client into memory read and write cycles on a synchronous parallel bus. A request carries an address, a direction flag and, for writes, a data word. The master drives the address on the rising clock edge that opens the cycle. It raises the memory-select and read strobes on the falling edge of that first cycle. It then keeps the cycle open for as long as the target holds its wait line high.

A cycle whose opening rising edge finds the wait line low is the final cycle. On its falling edge the master latches the incoming data bus and drops both strobes. One clock later it hands back the captured word with a single-cycle done pulse. The client may present the next request during the final cycle, and that request opens a new cycle on the very next rising edge. Only one transfer is in flight at a time. While a transfer is running, a low ready output holds the client off.

The sequencer has four states. IDLE waits for a request. ADDR is the first bus cycle. STALL is a wait cycle. LAST is the final cycle. The transitions are:
- IDLE→ADDR when a request is accepted.
- ADDR→STALL or STALL→STALL when wait is high at the rising edge.
- ADDR→LAST or STALL→LAST when wait is low at the rising edge.
- LAST→ADDR when a new request is accepted.
- LAST→IDLE when no request is pending.

Top module: `sbus_master`

## Requirements
- R1: After reset, req_ready is 1, and bus_mreq, bus_rd, rsp_done and bus_dout_en are all 0.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. bus_addr shows the request address right after that edge and holds it until the transfer ends.
- R3: bus_mreq stays 0 during the first half of the first cycle and goes to 1 on that cycle's falling edge.
- R4: bus_rd goes to 1 together with bus_mreq for a read and stays 0 for a write.
- R5: Each rising edge after the first cycle at which bus_wait is 1 adds one more cycle, during which address and strobes do not change. With N such edges, the transfer spans N+2 cycles.
- R6: For a read, rsp_rdata holds the bus_din value present at the falling edge of the final cycle. Later changes on bus_din do not alter it.
- R7: bus_mreq and bus_rd drop to 0 at the falling edge of the final cycle.
- R8: rsp_done is 1 for exactly one clock, starting at the rising edge that ends the final cycle.
- R9: req_ready is 0 during the first cycle and all wait cycles. A request presented then is not taken: the address does not change and no extra cycle runs.
- R10: req_ready is 1 in the final cycle. A request accepted there starts its first cycle on the next rising edge, with bus_mreq rising again on that cycle's falling edge.
- R11: For a write, bus_dout_en is 1 and bus_dout carries the write data from the first cycle to the end of the final cycle. For a read, bus_dout_en stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; cycles open on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client presents a request |
| req_ready | output | 1 | Master can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Bus address lines |
| bus_mreq | output | 1 | Memory-space select strobe (active high) |
| bus_rd | output | 1 | Read strobe (active high) |
| bus_wait | input | 1 | Target requests another cycle |
| bus_din | input | DATA_W | Data bus, inbound |
| bus_dout | output | DATA_W | Data bus, outbound |
| bus_dout_en | output | 1 | Outbound data drive enable |

## Verification
The bench changes bus_din right after the final falling edge; a master that captured on a rising edge, or one cycle late, would return the wrong word. It sweeps the wait count from zero to several cycles. A master that miscounted wait edges would finish one cycle early or late, and the strobe and done checks would show it. It offers a request while the master is busy and another during the final cycle. A wrong ready window would either swallow the first request or add a dead cycle before the second. It also samples bus_mreq before and after the first falling edge, which catches strobes raised together with the address.

// File: rtl/sbm_pkg.sv
`timescale 1ns/1ps
package sbm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_STALL = 2'd2,
        ST_LAST  = 2'd3
    } sbm_state_e;
endpackage

// File: rtl/sbm_seq.sv
`timescale 1ns/1ps
module sbm_seq
    import sbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       bus_wait,
    output sbm_state_e state,
    output logic       ready,
    output logic       accept
);
    sbm_state_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt    = state;
        ready  = 1'b0;
        accept = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ready  = 1'b1;
                accept = req_valid;
                if (req_valid) nxt = ST_ADDR;
            end
            ST_ADDR, ST_STALL: begin
                nxt = bus_wait ? ST_STALL : ST_LAST;
            end
            ST_LAST: begin
                ready  = 1'b1;
                accept = req_valid;
                nxt    = req_valid ? ST_ADDR : ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/sbm_strobe.sv
`timescale 1ns/1ps
module sbm_strobe
    import sbm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sbm_state_e        state,
    input  logic              is_write,
    input  logic [DATA_W-1:0] bus_din,
    output logic              mreq,
    output logic              rd,
    output logic [DATA_W-1:0] rdata
);
    // falling-edge strobe and capture logic
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mreq  <= 1'b0;
            rd    <= 1'b0;
            rdata <= '0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    mreq <= 1'b1;
                    rd   <= ~is_write;
                end
                ST_LAST: begin
                    mreq <= 1'b0;
                    rd   <= 1'b0;
                    if (!is_write) rdata <= bus_din;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sbus_master.sv
`timescale 1ns/1ps
module sbus_master
    import sbm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_mreq,
    output logic              bus_rd,
    input  logic              bus_wait,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en
);
    sbm_state_e state;
    logic       accept;
    logic       write_q;
    logic       done_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    sbm_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_wait  (bus_wait),
        .state     (state),
        .ready     (req_ready),
        .accept    (accept)
    );

    sbm_strobe #(.DATA_W(DATA_W)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .is_write (write_q),
        .bus_din  (bus_din),
        .mreq     (bus_mreq),
        .rd       (bus_rd),
        .rdata    (rsp_rdata)
    );

    // request registers, loaded on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state == ST_LAST);
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
            end
        end
    end

    assign bus_addr    = addr_q;
    assign bus_dout    = wdata_q;
    assign bus_dout_en = write_q && (state != ST_IDLE);
    assign rsp_done    = done_q;
endmodule

// File: rtl/sbm_chk.sv
`timescale 1ns/1ps
module sbm_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_mreq,
    input logic              bus_rd,
    input logic              bus_wait,
    input logic              bus_dout_en
);
    // R3
    mreq_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_mreq) |-> !req_ready);
    // R4
    rd_in_mreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> bus_mreq);
    // R5
    wait_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wait && bus_mreq && !req_ready) |=> (!req_ready && !rsp_done));
    // R7
    strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_mreq) |-> req_ready);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(bus_addr));
    // R11
    dout_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_en |-> !bus_rd);
endmodule

bind sbus_master sbm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .bus_addr    (bus_addr),
    .bus_mreq    (bus_mreq),
    .bus_rd      (bus_rd),
    .bus_wait    (bus_wait),
    .bus_dout_en (bus_dout_en)
);

// File: tb/test_sbus_master.sv
`timescale 1ns/1ps
module test_sbus_master;
    localparam int PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    // vector: [39:36] write, [35:32] wait count, [31:16] address, [15:0] data
    localparam int NV = 6;
    localparam logic [39:0] VEC [0:NV-1] = '{
        40'h0_0_1200_A5A5,
        40'h0_1_1204_3C3C,
        40'h1_0_2000_BEEF,
        40'h1_2_2002_0F0F,
        40'h0_4_FFFE_8001,
        40'h1_1_0000_7E7E
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, bus_wait = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, bus_din = '0;
    logic req_ready, rsp_done, bus_mreq, bus_rd, bus_dout_en;
    logic [DW-1:0] rsp_rdata, bus_dout;
    logic [AW-1:0] bus_addr;
    int total = 0, bad = 0;

    always #(PERIOD/2) clk = ~clk;

    sbus_master #(.ADDR_W(AW), .DATA_W(DW)) i_sbus_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
        .bus_mreq(bus_mreq), .bus_rd(bus_rd), .bus_wait(bus_wait),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #(PERIOD/4);
    endtask

    // one full transfer; entered and left at a quarter period after a rising edge
    task automatic xfer(input logic wr, input int nw, input logic [AW-1:0] a, input logic [DW-1:0] d);
        chk("R9 ready idle", req_ready, 1);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        step();
        req_valid = 0;
        bus_wait = (nw > 0);
        bus_din = ~d;
        chk("R2 addr", bus_addr, a);
        chk("R3 mreq low early", bus_mreq, 0);
        #(PERIOD/2);
        chk("R3 mreq on fall", bus_mreq, 1);
        chk("R4 rd", bus_rd, !wr);
        chk("R9 busy", req_ready, 0);
        chk("R11 dout_en", bus_dout_en, wr);
        if (wr) chk("R11 dout", bus_dout, d);
        for (int k = 1; k <= nw; k++) begin
            step();
            bus_wait = (k < nw);
            chk("R5 wait addr", bus_addr, a);
            chk("R5 wait mreq", bus_mreq, 1);
            chk("R5 wait busy", req_ready, 0);
        end
        step();
        bus_din = d;
        chk("R5 final mreq", bus_mreq, 1);
        chk("R10 final ready", req_ready, 1);
        chk("R8 no early done", rsp_done, 0);
        #(PERIOD/2);
        bus_din = ~d;
        chk("R7 mreq drop", bus_mreq, 0);
        chk("R7 rd drop", bus_rd, 0);
        chk("R11 dout_en final", bus_dout_en, wr);
        step();
        chk("R8 done", rsp_done, 1);
        if (!wr) chk("R6 rdata", rsp_rdata, d);
        chk("R11 dout_en off", bus_dout_en, 0);
        step();
        chk("R8 done one clock", rsp_done, 0);
    endtask

    initial begin
        #(200000 * PERIOD);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD/4);
        chk("R1 ready", req_ready, 1);
        chk("R1 mreq", bus_mreq, 0);
        chk("R1 rd", bus_rd, 0);
        chk("R1 done", rsp_done, 0);
        chk("R1 dout_en", bus_dout_en, 0);
        #(2 * PERIOD);
        rst_n = 1;
        step();

        for (int i = 0; i < NV; i++)
            xfer(VEC[i][36], int'(VEC[i][35:32]), VEC[i][31:16], VEC[i][15:0]);

        // R9: request offered while busy is not taken
        req_valid = 1; req_write = 0; req_addr = 16'h4000;
        step();
        req_addr = 16'h5000;
        bus_wait = 1;
        step();
        chk("R9 busy addr", bus_addr, 16'h4000);
        chk("R9 busy ready", req_ready, 0);
        step();
        chk("R9 busy addr 2", bus_addr, 16'h4000);
        bus_wait = 0; req_valid = 0; bus_din = 16'h1357;
        step();
        step();
        chk("R9 done", rsp_done, 1);
        chk("R6 rdata busy case", rsp_rdata, 16'h1357);
        chk("R9 addr kept", bus_addr, 16'h4000);
        #(PERIOD/2);
        chk("R9 no extra cycle", bus_mreq, 0);
        step();

        // R10: back-to-back read then write
        req_valid = 1; req_write = 0; req_addr = 16'h6000;
        step();
        req_write = 1; req_addr = 16'h6002; req_wdata = 16'hC0DE;
        bus_wait = 0; bus_din = 16'h2468;
        step();
        chk("R10 ready in final", req_ready, 1);
        step();
        req_valid = 0;
        chk("R10 done first", rsp_done, 1);
        chk("R10 rdata first", rsp_rdata, 16'h2468);
        chk("R10 next addr", bus_addr, 16'h6002);
        chk("R10 next dout_en", bus_dout_en, 1);
        chk("R10 mreq not yet", bus_mreq, 0);
        #(PERIOD/2);
        chk("R10 mreq again", bus_mreq, 1);
        chk("R10 write rd", bus_rd, 0);
        step();
        step();
        chk("R10 done second", rsp_done, 1);
        chk("R11 dout_en end", bus_dout_en, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule